// File: doc/BRIEF.md
# Blocking Direct-Mapped Write-Back Data Cache

This block is a single-level data cache between a processor and a slower memory. Every address maps to exactly one slot. Stores stay in the cache until their line is evicted. A store that misses first fetches the line into the cache. While a miss is being handled, no new request is taken. The processor side issues word loads and stores through a valid/ready handshake. Load results come back in order through a two-entry response queue, and popping that queue consumes the result.

On the memory side, two-entry queues carry whole-line write-backs and fill requests out of the block and take returned lines in. A four-state miss controller runs each miss as a fixed sequence: capture the request, write back a dirty victim, send the fill request, then install the returned line and finish the original access.

Top module: `dm_cache`

## Requirements
- R1: After reset every slot is invalid and clean, so the first access to any address misses. After reset `reqReady` is 1 and both `respValid` and `memReqValid` are 0.
- R2: The byte address is split as follows: bits [1:0] are ignored, bits [3:2] select the word within the 4-word line, bits [IDX_W+3:4] select the slot, and the rest form the tag.
- R3: A load that hits a valid slot with a matching tag puts the selected word in the response queue and causes no memory traffic.
- R4: A store that hits overwrites only the addressed word, marks the line dirty, and produces no response.
- R5: A miss is captured when it is accepted. From the next cycle, `reqReady` stays 0 while the controller moves through victim handling, then fill request, then fill wait, and back to ready. Each step is held until its queue permits it.
- R6: If the victim slot is valid and dirty, a write-back (`memReqIsWb`=1) goes out before the fill request. It carries the whole old line at address {old tag, index, 4'b0000}.
- R7: If the victim slot is clean or invalid, no write-back is issued, and the controller moves to the fill request on the next cycle.
- R8: The fill request has `memReqIsWb`=0 and carries the captured miss byte address.
- R9: When the returned line is installed, the tag becomes valid. A load miss leaves the line clean and returns the requested word. A store miss merges its word into the line and marks it dirty.
- R10: All three queues hold two entries. `reqReady` is 0 while the response queue is full. `memRespReady` is 0 while the fill queue is full.
- R11: Within `memReqLine` and `memRespLine`, word w occupies bits [w*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Request accepted at this edge when valid |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address |
| reqData | input | DATA_W | Store data |
| respValid | output | 1 | Load result available |
| respData | output | DATA_W | Load result word |
| respPop | input | 1 | Consume the current load result |
| memReqValid | output | 1 | Memory request available |
| memReqPop | input | 1 | Memory takes the current request |
| memReqIsWb | output | 1 | 1 = line write-back, 0 = fill request |
| memReqAddr | output | ADDR_W | Request byte address |
| memReqLine | output | 4*DATA_W | Write-back line (zero for fills) |
| memRespValid | input | 1 | Returned line present |
| memRespReady | output | 1 | Fill queue has room |
| memRespLine | input | 4*DATA_W | Returned line |

## Verification
The assertions assume the memory returns exactly one line for each fill request and none for a write-back. They also assume the environment never pushes a returned line while the fill queue is full. Under these assumptions, the response-queue check can rely on a single outstanding miss. The behavioural memory in the bench consumes one request at a time and sends back one line per fill after a configurable latency. It holds that line until `memRespReady` is seen, so the assumed protocol is never broken. The processor driver keeps to the valid/ready handshake and stays within a small address window, so slots are forced to conflict often.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_START = 2'd1,
    ST_SEND  = 2'd2,
    ST_WAIT  = 2'd3
  } missState_t;

  typedef struct packed {
    logic hitRd;
    logic hitWr;
    logic capture;
    logic wbPush;
    logic fillPush;
    logic install;
  } strobes_t;

endpackage

// File: rtl/dm_cache_fifo.sv
module dm_cache_fifo #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] slot [2];
  logic         wrP, rdP;
  logic [1:0]   cnt;
  logic         doPush, doPop;

  assign full   = (cnt == 2'd2);
  assign empty  = (cnt == 2'd0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = slot[rdP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrP <= 1'b0;
      rdP <= 1'b0;
      cnt <= 2'd0;
    end else begin
      if (doPush) wrP <= ~wrP;
      if (doPop)  rdP <= ~rdP;
      cnt <= cnt + {1'b0, doPush} - {1'b0, doPop};
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slot[wrP] <= din;
  end
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIsStore,
  input  logic       lookupHit,
  input  logic       victimDirty,
  input  logic       respFull,
  input  logic       mreqFull,
  input  logic       mrespEmpty,
  output logic       reqReady,
  output missState_t state,
  output strobes_t   strb
);
  missState_t stateNext;
  logic       accept;

  assign reqReady = (state == ST_READY) && !respFull;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strb          = '0;
    strb.hitRd    = accept && lookupHit && !reqIsStore;
    strb.hitWr    = accept && lookupHit && reqIsStore;
    strb.capture  = accept && !lookupHit;
    strb.wbPush   = (state == ST_START) && victimDirty && !mreqFull;
    strb.fillPush = (state == ST_SEND) && !mreqFull;
    strb.install  = (state == ST_WAIT) && !mrespEmpty;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_READY: if (strb.capture) stateNext = ST_START;
      ST_START: if (!victimDirty || !mreqFull) stateNext = ST_SEND;
      ST_SEND:  if (strb.fillPush) stateNext = ST_WAIT;
      ST_WAIT:  if (strb.install) stateNext = ST_READY;
      default:  stateNext = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_READY;
    else       state <= stateNext;
  end
endmodule

// File: rtl/dm_cache_dpath.sv
module dm_cache_dpath
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strb,
  input  logic                reqIsStore,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic                respPop,
  input  logic                memReqPop,
  input  logic                memRespValid,
  input  logic [4*DATA_W-1:0] memRespLine,
  output logic                lookupHit,
  output logic                victimDirty,
  output logic                missIsStore,
  output logic                respFull,
  output logic                mreqFull,
  output logic                mrespEmpty,
  output logic                respValid,
  output logic [DATA_W-1:0]   respData,
  output logic                memReqValid,
  output logic                memReqIsWb,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [4*DATA_W-1:0] memReqLine,
  output logic                memRespReady
);
  localparam int LINES  = 1 << IDX_W;
  localparam int OFF_LO = 4;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_LO;
  localparam int LINE_W = 4 * DATA_W;
  localparam int MREQ_W = 1 + ADDR_W + LINE_W;

  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINE_W-1:0] dataArr [LINES];
  logic [LINES-1:0]  validArr, dirtyArr;

  logic [ADDR_W-1:0] missAddr;
  logic [DATA_W-1:0] missData;

  logic [IDX_W-1:0]  reqIdx, missIdx;
  logic [TAG_W-1:0]  reqTag, missTag;
  logic [1:0]        reqOff, missOff;
  logic              unusedByteBits;

  assign reqIdx  = reqAddr[OFF_LO +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqOff  = reqAddr[3:2];
  assign missIdx = missAddr[OFF_LO +: IDX_W];
  assign missTag = missAddr[ADDR_W-1 -: TAG_W];
  assign missOff = missAddr[3:2];
  assign unusedByteBits = ^{reqAddr[1:0], reqIsStore};

  assign lookupHit   = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validArr[missIdx] && dirtyArr[missIdx];

  // fill queue
  logic [LINE_W-1:0] fillHead, fillMerged;
  logic              mrespFull;
  assign memRespReady = !mrespFull;

  dm_cache_fifo #(.W(LINE_W)) u_mrespQ (
    .clk(clk), .rstN(rstN),
    .push(memRespValid), .din(memRespLine),
    .pop(strb.install), .dout(fillHead),
    .full(mrespFull), .empty(mrespEmpty)
  );

  always_comb begin
    fillMerged = fillHead;
    if (missIsStore) fillMerged[missOff*DATA_W +: DATA_W] = missData;
  end

  // processor response queue
  logic              respPush, respEmpty;
  logic [DATA_W-1:0] respIn, hitWord, fillWord;
  logic [LINE_W-1:0] hitLine;
  assign hitLine  = dataArr[reqIdx];
  assign hitWord  = hitLine[reqOff*DATA_W +: DATA_W];
  assign fillWord = fillHead[missOff*DATA_W +: DATA_W];
  assign respPush = strb.hitRd || (strb.install && !missIsStore);
  assign respIn   = strb.hitRd ? hitWord : fillWord;
  assign respValid = !respEmpty;

  dm_cache_fifo #(.W(DATA_W)) u_respQ (
    .clk(clk), .rstN(rstN),
    .push(respPush), .din(respIn),
    .pop(respPop), .dout(respData),
    .full(respFull), .empty(respEmpty)
  );

  // memory request queue
  logic [MREQ_W-1:0] mreqIn, mreqOut;
  logic              mreqEmpty;
  always_comb begin
    if (strb.wbPush)
      mreqIn = {1'b1, tagArr[missIdx], missIdx, 4'b0000, dataArr[missIdx]};
    else
      mreqIn = {1'b0, missAddr, {LINE_W{1'b0}}};
  end
  assign memReqValid = !mreqEmpty;
  assign {memReqIsWb, memReqAddr, memReqLine} = mreqOut;

  dm_cache_fifo #(.W(MREQ_W)) u_mreqQ (
    .clk(clk), .rstN(rstN),
    .push(strb.wbPush || strb.fillPush), .din(mreqIn),
    .pop(memReqPop), .dout(mreqOut),
    .full(mreqFull), .empty(mreqEmpty)
  );

  // miss register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) missIsStore <= 1'b0;
    else if (strb.capture) missIsStore <= reqIsStore;
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      missAddr <= reqAddr;
      missData <= reqData;
    end
  end

  // per-slot state
  for (genvar s = 0; s < LINES; s++) begin : g_slot
    logic hitWrHere, installHere;
    assign hitWrHere   = strb.hitWr && (reqIdx == IDX_W'(s));
    assign installHere = strb.install && (missIdx == IDX_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validArr[s] <= 1'b0;
        dirtyArr[s] <= 1'b0;
      end else if (installHere) begin
        validArr[s] <= 1'b1;
        dirtyArr[s] <= missIsStore;
      end else if (hitWrHere) begin
        dirtyArr[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (installHere) begin
        tagArr[s]  <= missTag;
        dataArr[s] <= fillMerged;
      end else if (hitWrHere) begin
        dataArr[s][reqOff*DATA_W +: DATA_W] <= reqData;
      end
    end
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqIsStore,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  output logic                respValid,
  output logic [DATA_W-1:0]   respData,
  input  logic                respPop,
  output logic                memReqValid,
  input  logic                memReqPop,
  output logic                memReqIsWb,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [4*DATA_W-1:0] memReqLine,
  input  logic                memRespValid,
  output logic                memRespReady,
  input  logic [4*DATA_W-1:0] memRespLine
);
  missState_t ctrlState;
  strobes_t   strb;
  logic       lookupHit, victimDirty, missIsStore;
  logic       respFull, mreqFull, mrespEmpty;

  dm_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsStore(reqIsStore),
    .lookupHit(lookupHit), .victimDirty(victimDirty),
    .respFull(respFull), .mreqFull(mreqFull), .mrespEmpty(mrespEmpty),
    .reqReady(reqReady), .state(ctrlState), .strb(strb)
  );

  dm_cache_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqIsStore(reqIsStore), .reqAddr(reqAddr), .reqData(reqData),
    .respPop(respPop), .memReqPop(memReqPop),
    .memRespValid(memRespValid), .memRespLine(memRespLine),
    .lookupHit(lookupHit), .victimDirty(victimDirty), .missIsStore(missIsStore),
    .respFull(respFull), .mreqFull(mreqFull), .mrespEmpty(mrespEmpty),
    .respValid(respValid), .respData(respData),
    .memReqValid(memReqValid), .memReqIsWb(memReqIsWb),
    .memReqAddr(memReqAddr), .memReqLine(memReqLine),
    .memRespReady(memRespReady)
  );
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input missState_t        state,
  input logic              reqValid,
  input logic              reqReady,
  input logic              lookupHit,
  input logic              victimDirty,
  input logic              missIsStore,
  input logic              respFull,
  input logic              mrespEmpty,
  input logic              memReqValid,
  input logic              memReqIsWb,
  input logic [ADDR_W-1:0] memReqAddr
);
  assert_miss_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lookupHit) |=> (state == ST_START && !reqReady));

  assert_start_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START) |=> (state == ST_START || state == ST_SEND));

  assert_send_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |=> (state == ST_SEND || state == ST_WAIT));

  assert_clean_skip_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && !victimDirty) |=> (state == ST_SEND));

  assert_wb_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqIsWb) |-> (memReqAddr[3:0] == 4'b0000));

  assert_install_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !mrespEmpty) |=> (state == ST_READY));

  assert_resp_room_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !mrespEmpty && !missIsStore) |-> !respFull);
endmodule

bind dm_cache dm_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .state(ctrlState),
  .reqValid(reqValid), .reqReady(reqReady),
  .lookupHit(lookupHit), .victimDirty(victimDirty), .missIsStore(missIsStore),
  .respFull(respFull), .mrespEmpty(mrespEmpty),
  .memReqValid(memReqValid), .memReqIsWb(memReqIsWb), .memReqAddr(memReqAddr)
);

// File: tb/dm_cache_bench.sv
`timescale 1ns/1ps
module dm_cache_bench;
  localparam int NWORDS = 256;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqIsStore = 1'b0;
  logic [31:0]  reqAddr = '0, reqData = '0;
  logic         reqReady, respValid, respPop;
  logic [31:0]  respData;
  logic         memReqValid, memReqPop, memReqIsWb, memRespReady;
  logic [31:0]  memReqAddr;
  logic [127:0] memReqLine;
  logic         memRespValid = 1'b0;
  logic [127:0] memRespLine = '0;

  always #5 clk = ~clk;

  dm_cache u_dm_cache (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqIsStore(reqIsStore),
    .reqAddr(reqAddr), .reqData(reqData),
    .respValid(respValid), .respData(respData), .respPop(respPop),
    .memReqValid(memReqValid), .memReqPop(memReqPop), .memReqIsWb(memReqIsWb),
    .memReqAddr(memReqAddr), .memReqLine(memReqLine),
    .memRespValid(memRespValid), .memRespReady(memRespReady), .memRespLine(memRespLine)
  );

  logic [31:0] memWords [NWORDS];
  logic [31:0] refMem   [NWORDS];
  logic [31:0] expQ [$];
  int vectors = 0, fails = 0;
  int memLat = 2, wbCount = 0, fillCount = 0;
  logic [31:0] lastWbAddr = '0, lastFillAddr = '0;
  logic popEn = 1'b1, memBusy = 1'b0, finished = 1'b0;

  assign respPop   = popEn;
  assign memReqPop = !memBusy;

  function automatic logic [31:0] initWord(int i);
    return (32'(i) * 32'h0001_0203) ^ 32'h5A00_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && respValid && respPop) begin
      if (expQ.size() == 0) check(1'b0, "R3 unexpected response", respData, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(respData == e, "R3/R9 load data", respData, e);
      end
    end
  end

  // behavioural memory
  initial begin
    for (int i = 0; i < NWORDS; i++) memWords[i] = initWord(i);
    forever begin
      @(negedge clk);
      if (rstN && memReqValid && !memBusy) begin
        if (memReqIsWb) begin
          for (int w = 0; w < 4; w++)
            memWords[{memReqAddr[9:4], 2'(w)}] = memReqLine[w*32 +: 32];
          wbCount++;
          lastWbAddr = memReqAddr;
        end else begin
          logic [5:0] ln;
          fillCount++;
          lastFillAddr = memReqAddr;
          ln = memReqAddr[9:4];
          @(posedge clk);
          #1 memBusy = 1'b1;
          @(negedge clk);
          repeat (memLat) @(negedge clk);
          for (int w = 0; w < 4; w++) memRespLine[w*32 +: 32] = memWords[{ln, 2'(w)}];
          memRespValid = 1'b1;
          while (!memRespReady) @(negedge clk);
          @(negedge clk);
          memRespValid = 1'b0;
          memBusy = 1'b0;
        end
      end
    end
  end

  // driver: pushes expected load results into the scoreboard
  task automatic doOp(input bit st, input logic [31:0] a, input logic [31:0] d);
    reqIsStore = st;
    reqAddr = a;
    reqData = d;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    if (st) refMem[a[9:2]] = d;
    else    expQ.push_back(refMem[a[9:2]]);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (expQ.size() != 0 || !reqReady || respValid || memBusy);
    @(negedge clk);
  endtask

  localparam logic [31:0] A = 32'h010, B = 32'h110, C = 32'h210;

  initial begin
    int f0, w0;
    for (int i = 0; i < NWORDS; i++) refMem[i] = initWord(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", 32'(reqReady), 32'd1);
    check(respValid == 1'b0, "R1 no response after reset", 32'(respValid), 32'd0);
    check(memReqValid == 1'b0, "R1 no memory request after reset", 32'(memReqValid), 32'd0);

    // cold load miss
    doOp(1'b0, A, '0);
    check(reqReady == 1'b0, "R5 blocked during miss", 32'(reqReady), 32'd0);
    drain();
    check(fillCount == 1, "R1 cold access misses", 32'(fillCount), 32'd1);
    check(lastFillAddr == A, "R8 fill address", lastFillAddr, A);
    check(wbCount == 0, "R7 no write-back for invalid victim", 32'(wbCount), 32'd0);

    // load hit with byte offset bits set
    doOp(1'b0, A + 32'd1, '0);
    doOp(1'b0, A + 32'd12, '0);
    drain();
    check(fillCount == 1, "R2 R3 hit causes no fill", 32'(fillCount), 32'd1);

    // store hit, then read it back
    doOp(1'b1, A + 32'd4, 32'hDEAD_BEEF);
    doOp(1'b0, A + 32'd4, '0);
    doOp(1'b0, A + 32'd8, '0);
    drain();
    check(fillCount == 1, "R4 store hit causes no fill", 32'(fillCount), 32'd1);

    // conflict evicts dirty A
    doOp(1'b0, B, '0);
    drain();
    check(wbCount == 1, "R6 dirty victim written back", 32'(wbCount), 32'd1);
    check(lastWbAddr == A, "R6 write-back address", lastWbAddr, A);
    check(memWords[5] == 32'hDEAD_BEEF, "R6 R11 write-back line word 1", memWords[5], 32'hDEAD_BEEF);
    check(memWords[4] == initWord(4), "R4 untouched word kept", memWords[4], initWord(4));
    check(fillCount == 2, "R8 fill after write-back", 32'(fillCount), 32'd2);

    // clean victim B
    doOp(1'b0, C, '0);
    drain();
    check(wbCount == 1, "R7 clean victim not written back", 32'(wbCount), 32'd1);

    // store miss, read it, then evict
    doOp(1'b1, A + 32'd8, 32'h1234_5678);
    check(reqReady == 1'b0, "R5 blocked during store miss", 32'(reqReady), 32'd0);
    drain();
    f0 = fillCount;
    doOp(1'b0, A + 32'd8, '0);
    doOp(1'b0, A + 32'd4, '0);
    drain();
    check(fillCount == f0, "R9 store-miss line installed", 32'(fillCount), 32'(f0));
    w0 = wbCount;
    doOp(1'b0, B, '0);
    drain();
    check(wbCount == w0 + 1, "R9 store miss leaves line dirty", 32'(wbCount), 32'(w0 + 1));
    check(memWords[6] == 32'h1234_5678, "R9 merged word written back", memWords[6], 32'h1234_5678);

    // load miss leaves line clean
    w0 = wbCount;
    doOp(1'b0, C + 32'd4, '0);
    drain();
    check(wbCount == w0, "R9 load-miss line is clean", 32'(wbCount), 32'(w0));

    // response queue full
    doOp(1'b0, C, '0);
    drain();
    popEn = 1'b0;
    doOp(1'b0, C, '0);
    doOp(1'b0, C + 32'd8, '0);
    check(reqReady == 1'b0, "R10 ready low when response queue full", 32'(reqReady), 32'd0);
    check(respValid == 1'b1, "R10 responses held", 32'(respValid), 32'd1);
    popEn = 1'b1;
    drain();

    // random traffic at two latencies
    for (int ph = 0; ph < 2; ph++) begin
      memLat = (ph == 0) ? 0 : 5;
      for (int n = 0; n < 300; n++) begin
        logic [7:0] wi;
        bit st;
        wi = 8'($urandom);
        st = ($urandom % 3) == 0;
        doOp(st, {22'd0, wi, st ? 2'b00 : 2'($urandom)}, $urandom);
        if (($urandom % 5) == 0) popEn = 1'b0;
        else popEn = 1'b1;
        if (!reqReady && !popEn) popEn = 1'b1;
      end
      popEn = 1'b1;
      drain();
    end
    check(expQ.size() == 0, "R3 all loads answered", 32'(expQ.size()), 32'd0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", 32'd0, 32'd1);
    summary();
  end
endmodule